// File: doc/BRIEF.md
# Cell-Balancer Test Mode Latch

This block adds a production test mode to a cell-balancing protection controller. An analog front end turns a raised supply level into one digital request bit. Test mode starts only when that request stays high for a set number of consecutive clock cycles and no cell is above its balance-detect level. Once started, test mode is held in a latch even after the request goes away. While it is held, the block signals the detection timers to use short delays, and it forces every bleed switch open.

While test mode is active, the alarm output is driven by a small trip detector instead of the normal protection logic. With the request high, the detector trips on any cell above the balance-detect level. It then releases only after the request has dropped and every cell is at or below the balance-release level. With the request low, it trips on any cell above the overcharge level and releases when every cell is at or below the overcharge-release level. When the alarm goes from detected back to released, the latch clears, so each entry into test mode covers exactly one detect-and-release cycle. Outside test mode, the alarm follows the normal protection alarm and the bleed requests pass through unchanged.

Top module: `cbal_test_latch`

## Requirements
- R1: After reset, test mode is off, the fast-delay indication is low, and the trip detector is cleared.
- R2: Test mode turns on at the end of the ENTRY_CYC-th consecutive clock cycle in which the request is high, no cell is above balance-detect, and test mode is not already on.
- R3: A request that stays high for fewer than ENTRY_CYC consecutive cycles has no effect. Any low cycle restarts the count from zero.
- R4: While any cell is above its balance-detect level, the entry count stays at zero and test mode cannot start.
- R5: Once on, test mode stays on after the request goes low, until the trip detector releases.
- R6: In test mode with the request high, the alarm becomes active after any cell has been above balance-detect for TEST_DLY consecutive cycles. A gap in that condition restarts the count.
- R7: After a trip on balance-detect, the alarm stays active while the request is high or while any cell is above balance-release. It releases on the first cycle in which neither is true.
- R8: In test mode with the request low, the alarm becomes active after any cell has been above overcharge for TEST_DLY consecutive cycles, and cells above balance-detect do not trip it. After such a trip, it releases on the first cycle in which no cell is above overcharge-release.
- R9: The same clock edge that releases the trip detector also turns test mode off.
- R10: While test mode is on, all bleed outputs are 0. Otherwise each bleed output equals its bleed request.
- R11: The fast-delay indication is high exactly while test mode is on.
- R12: With OUT_ACT_LOW = 0, the alarm output is high when active. Outside test mode it equals the normal alarm input. Inside test mode it ignores the normal alarm input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Test-entry request level from the analog front end |
| bal_hi_i | input | NCELL | Per cell: voltage above balance-detect level |
| bal_lo_i | input | NCELL | Per cell: voltage above balance-release level |
| ovc_hi_i | input | NCELL | Per cell: voltage above overcharge level |
| ovc_lo_i | input | NCELL | Per cell: voltage above overcharge-release level |
| bleed_req_i | input | NCELL | Bleed switch requests from the balancer |
| norm_alarm_i | input | 1 | Alarm from the normal protection logic |
| test_o | output | 1 | Test mode latch state |
| fast_o | output | 1 | Use shortened detection delays |
| bleed_o | output | NCELL | Gated bleed switch controls |
| alarm_o | output | 1 | Alarm output pin level |

## Verification
The bench builds the block with NCELL = 3, ENTRY_CYC = 6 and TEST_DLY = 4, using an active-high output. These small counts let the bench try every too-short request length from 1 up to ENTRY_CYC - 1 and every delay boundary cycle by cycle. Each cell is used on its own as the tripping cell, once in the balance-detect path and once in the overcharge path. Each cell is also used as the blocker of entry.

// File: rtl/tml_pkg.sv
package tml_pkg;
    typedef enum logic {
        PATH_BAL = 1'b0,
        PATH_OVC = 1'b1
    } trip_path_e;
endpackage

// File: rtl/tml_entry_qual.sv
module tml_entry_qual #(
    parameter int ENTRY_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic block_i,
    input  logic hold_i,
    output logic enter_o
);
    localparam int ECW = $clog2(ENTRY_CYC + 1);
    localparam logic [ECW-1:0] LAST = ECW'(ENTRY_CYC - 1);

    typedef struct packed {
        logic [ECW-1:0] cnt;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d   = cur_q;
        enter_o = 1'b0;
        if (hold_i || !req_i || block_i) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == LAST) begin
            enter_o   = 1'b1;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // the qualifier never counts past its terminal value
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LAST);

    // a blocked cycle always leaves the count at zero
    assert_block_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> cur_q.cnt == '0);
endmodule

// File: rtl/tml_trip_det.sv
module tml_trip_det
    import tml_pkg::*;
#(
    parameter int NCELL    = 5,
    parameter int TEST_DLY = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             req_i,
    input  logic [NCELL-1:0] bal_hi_i,
    input  logic [NCELL-1:0] bal_lo_i,
    input  logic [NCELL-1:0] ovc_hi_i,
    input  logic [NCELL-1:0] ovc_lo_i,
    output logic             det_o,
    output logic             release_o
);
    localparam int DCW = $clog2(TEST_DLY + 1);
    localparam logic [DCW-1:0] LAST = DCW'(TEST_DLY - 1);

    typedef struct packed {
        logic           det;
        trip_path_e     path;
        logic [DCW-1:0] cnt;
    } det_t;

    det_t cur_q, nxt_d;
    logic cond;
    logic rel_cond;

    always_comb begin
        nxt_d     = cur_q;
        release_o = 1'b0;
        cond      = req_i ? (|bal_hi_i) : (|ovc_hi_i);
        rel_cond  = (cur_q.path == PATH_BAL) ? (!req_i && !(|bal_lo_i))
                                             : !(|ovc_lo_i);
        if (!active_i) begin
            nxt_d = '0;
        end else if (!cur_q.det) begin
            if (!cond) begin
                nxt_d.cnt = '0;
            end else if (cur_q.cnt == LAST) begin
                nxt_d.det  = 1'b1;
                nxt_d.path = req_i ? PATH_BAL : PATH_OVC;
                nxt_d.cnt  = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end else if (rel_cond) begin
            nxt_d.det = 1'b0;
            release_o = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign det_o = cur_q.det;

    // a trip always follows a cycle in which a detect flag was present
    assert_trip_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.det) |-> $past(|bal_hi_i) || $past(|ovc_hi_i));

    // a balance-path release never happens while the request is high
    assert_bal_rel_req_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cur_q.det) && $past(cur_q.path) == PATH_BAL) |-> !$past(req_i));
endmodule

// File: rtl/cbal_test_latch.sv
module cbal_test_latch #(
    parameter int NCELL       = 5,
    parameter int ENTRY_CYC   = 10,
    parameter int TEST_DLY    = 32,
    parameter bit OUT_ACT_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [NCELL-1:0] bal_hi_i,
    input  logic [NCELL-1:0] bal_lo_i,
    input  logic [NCELL-1:0] ovc_hi_i,
    input  logic [NCELL-1:0] ovc_lo_i,
    input  logic [NCELL-1:0] bleed_req_i,
    input  logic             norm_alarm_i,
    output logic             test_o,
    output logic             fast_o,
    output logic [NCELL-1:0] bleed_o,
    output logic             alarm_o
);
    typedef struct packed {
        logic test;
    } top_t;

    top_t cur_q, nxt_d;
    logic enter;
    logic det;
    logic release_evt;
    logic alarm_raw;

    tml_entry_qual #(.ENTRY_CYC(ENTRY_CYC)) qual_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .block_i (|bal_hi_i),
        .hold_i  (cur_q.test),
        .enter_o (enter)
    );

    tml_trip_det #(.NCELL(NCELL), .TEST_DLY(TEST_DLY)) trip_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (cur_q.test),
        .req_i     (req_i),
        .bal_hi_i  (bal_hi_i),
        .bal_lo_i  (bal_lo_i),
        .ovc_hi_i  (ovc_hi_i),
        .ovc_lo_i  (ovc_lo_i),
        .det_o     (det),
        .release_o (release_evt)
    );

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.test) nxt_d.test = !release_evt;
        else            nxt_d.test = enter;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign test_o    = cur_q.test;
    assign fast_o    = cur_q.test;
    assign alarm_raw = cur_q.test ? det : norm_alarm_i;

    for (genvar c = 0; c < NCELL; c++) begin : g_bleed
        assign bleed_o[c] = bleed_req_i[c] & ~cur_q.test;
    end

    if (OUT_ACT_LOW) begin : g_pol_lo
        assign alarm_o = ~alarm_raw;
    end else begin : g_pol_hi
        assign alarm_o = alarm_raw;
    end

    assert_entry_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.test) |-> $past(req_i));

    assert_entry_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.test) |-> $past(bal_hi_i) == '0);

    assert_exit_after_detect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur_q.test) |-> $past(det));

    assert_det_inside_test_R5: assert property (@(posedge clk) disable iff (!rst_n)
        det |-> cur_q.test);

    assert_no_bleed_in_test_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.test |-> bleed_o == '0);
endmodule

// File: tb/cbal_test_latch_tb_top.sv
module cbal_test_latch_tb_top;
    localparam int NC = 3;
    localparam int EC = 6;
    localparam int TD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [NC-1:0] bal_hi = '0, bal_lo = '0, ovc_hi = '0, ovc_lo = '0, bleed_req = '0;
    logic norm = 1'b0;
    logic test, fast, alarm;
    logic [NC-1:0] bleed;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    cbal_test_latch #(.NCELL(NC), .ENTRY_CYC(EC), .TEST_DLY(TD), .OUT_ACT_LOW(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req),
        .bal_hi_i(bal_hi), .bal_lo_i(bal_lo), .ovc_hi_i(ovc_hi), .ovc_lo_i(ovc_lo),
        .bleed_req_i(bleed_req), .norm_alarm_i(norm),
        .test_o(test), .fast_o(fast), .bleed_o(bleed), .alarm_o(alarm)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
        end
    endtask

    task automatic enter_test();
        req = 1'b1;
        step(EC);
        check("R2 entry", {31'd0, test}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        check("R1 test off", {31'd0, test}, 32'd0);
        check("R1 fast off", {31'd0, fast}, 32'd0);
        check("R1 alarm off", {31'd0, alarm}, 32'd0);
        bleed_req = 3'b101;
        norm = 1'b1;
        step(1);
        check("R10 bleed pass", {29'd0, bleed}, 32'd5);
        check("R12 normal alarm pass", {31'd0, alarm}, 32'd1);
        norm = 1'b0;
        step(1);
        check("R12 normal alarm low", {31'd0, alarm}, 32'd0);

        // R3: every too-short pulse length
        for (int len = 1; len < EC; len++) begin
            req = 1'b1;
            step(len);
            req = 1'b0;
            step(1);
            check("R3 short pulse", {31'd0, test}, 32'd0);
        end

        // R4: each cell blocks entry
        for (int c = 0; c < NC; c++) begin
            bal_hi = NC'(1 << c);
            req = 1'b1;
            step(EC + 2);
            check("R4 blocked", {31'd0, test}, 32'd0);
            req = 1'b0;
            bal_hi = '0;
            step(1);
        end

        // R2 boundary, R11, R10
        req = 1'b1;
        step(EC - 1);
        check("R2 one short", {31'd0, test}, 32'd0);
        step(1);
        check("R2 entered", {31'd0, test}, 32'd1);
        check("R11 fast on", {31'd0, fast}, 32'd1);
        bleed_req = 3'b111;
        norm = 1'b1;
        step(1);
        check("R10 bleed gated", {29'd0, bleed}, 32'd0);
        check("R12 normal ignored", {31'd0, alarm}, 32'd0);
        norm = 1'b0;

        // balance path per cell
        for (int c = 0; c < NC; c++) begin
            if (c != 0) enter_test();
            // R6 gap restarts count
            bal_hi = NC'(1 << c);
            step(TD - 1);
            bal_hi = '0;
            step(1);
            bal_hi = NC'(1 << c);
            step(TD - 1);
            check("R6 gap no trip", {31'd0, alarm}, 32'd0);
            step(1);
            check("R6 balance trip", {31'd0, alarm}, 32'd1);
            bal_hi = '0;
            bal_lo = NC'(1 << c);
            step(2);
            bal_lo = '0;
            step(2);
            check("R7 held by request", {31'd0, alarm}, 32'd1);
            req = 1'b0;
            bal_lo = NC'(1 << c);
            step(2);
            check("R5 latch holds", {31'd0, test}, 32'd1);
            check("R7 held by cell", {31'd0, alarm}, 32'd1);
            bal_lo = '0;
            step(1);
            check("R7 release", {31'd0, alarm}, 32'd0);
            check("R9 exit", {31'd0, test}, 32'd0);
            check("R11 fast off", {31'd0, fast}, 32'd0);
            check("R10 bleed restored", {29'd0, bleed}, 32'd7);
        end

        // overcharge path per cell
        for (int c = 0; c < NC; c++) begin
            enter_test();
            req = 1'b0;
            step(3);
            check("R5 latch after drop", {31'd0, test}, 32'd1);
            bal_hi = NC'(1 << c);
            step(TD + 2);
            check("R8 balance ignored", {31'd0, alarm}, 32'd0);
            bal_hi = '0;
            ovc_hi = NC'(1 << c);
            step(TD - 1);
            check("R8 not yet", {31'd0, alarm}, 32'd0);
            step(1);
            check("R8 overcharge trip", {31'd0, alarm}, 32'd1);
            ovc_hi = '0;
            ovc_lo = NC'(1 << c);
            step(3);
            check("R8 held", {31'd0, alarm}, 32'd1);
            ovc_lo = '0;
            step(1);
            check("R8 release", {31'd0, alarm}, 32'd0);
            check("R9 exit ovc", {31'd0, test}, 32'd0);
        end

        step(EC + 2);
        check("R5 stays off", {31'd0, test}, 32'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule